// File: doc/BRIEF.md
# Banked Interrupt Controller with Normal and Fast Outputs

This block gathers 96 level-sensitive interrupt sources, organised as three banks of 32, and turns them into two request lines for a processor: a normal interrupt and a fast interrupt. Software reaches it through a plain 32-bit register port inside a 1 KB address window. Per bank it can mask sources, choose which unmasked sources also raise the fast line, and keep enable bits. A vector register gives the byte-scaled index of the lowest-numbered active source, so a handler can index a table of four-byte entries with it directly.

The pending state is a registered copy of the input levels and cannot be written. Both outputs and the vector are registered. They change on the clock edge that captures an input change or that performs a register write affecting them. Read data is combinational from the address. Base-address, protect and NMI words are held for software and have no effect on the function.

Top module: `irqc_top`

## Requirements
- R1: Pending bank b (read at 0x10 + 4*b, b = 0..2) shows bit i equal to the level of source 32*b+i as sampled on the previous rising clock edge.
- R2: `cpu_irq` is 1 one edge after some source is high and its mask bit (bank at 0x50 + 4*b) is 0, and 0 when no such source exists; a mask bit of 1 blocks its source.
- R3: `cpu_fiq` is 1 when some source is high, unmasked, and has its select bit (bank at 0x30 + 4*b) set, and 0 otherwise; `cpu_fiq` never stands without `cpu_irq`.
- R4: The vector word at 0x00 holds 4*n for the lowest-numbered high, unmasked source n (bank 0 searched first), and 0 when there is none.
- R5: A write to a pending word is accepted and changes nothing.
- R6: The fast-pending words at 0x20 + 4*b are write-one-to-clear: each 1 in the written data clears that bit. Nothing sets them, so they read 0 after reset.
- R7: A write to the base word at 0x04 stores the data with bits [1:0] forced to 0.
- R8: Select, enable (0x40 + 4*b), mask, protect (0x08) and NMI (0x0C) read back what was last written; enable bits have no effect on either output or the vector.
- R9: Reset (synchronous, active high) clears every register, the vector and both outputs.
- R10: A read from any address not listed above, including word 3 of a banked group and unaligned addresses, returns 0; a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 96 | Source levels, bit n is source n |
| reg_addr | input | 10 | Byte address within the window |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr, combinational |
| cpu_irq | output | 1 | Normal interrupt request |
| cpu_fiq | output | 1 | Fast interrupt request |

## Verification
The assertions assume the source levels and the write strobe are clean synchronous signals, settled before each rising edge, and that the reset is held high from time zero for at least one edge. The stimulus respects this by changing every input only on the falling edge and by raising reset before the first clock. The relation between pending state and the previous input level is checked on every cycle after reset, so writes aimed at the pending words are exercised while sources toggle around them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_BANKS = 3;
    localparam int BANK_W    = 32;
    localparam int NUM_SRC   = NUM_BANKS * BANK_W;
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 32;

    // word offsets in the window
    localparam logic [ADDR_W-1:0] OFF_VEC   = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_BASE  = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_PROT  = 10'h008;
    localparam logic [ADDR_W-1:0] OFF_NMI   = 10'h00C;
    localparam logic [ADDR_W-1:0] OFF_PEND  = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_FPEND = 10'h020;
    localparam logic [ADDR_W-1:0] OFF_SEL   = 10'h030;
    localparam logic [ADDR_W-1:0] OFF_EN    = 10'h040;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 10'h050;

    typedef enum logic [3:0] {
        GRP_NONE,
        GRP_VEC,
        GRP_BASE,
        GRP_PROT,
        GRP_NMI,
        GRP_PEND,
        GRP_FPEND,
        GRP_SEL,
        GRP_EN,
        GRP_MASK
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e   grp;
        logic [1:0] bank;
    } reg_sel_t;

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_vec_t;

    // Map a byte address onto a register group and bank word.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t d;
        logic [ADDR_W-5:0] blk;
        d.grp  = GRP_NONE;
        d.bank = a[3:2];
        blk    = a[ADDR_W-1:4];
        if (a[1:0] == 2'b00) begin
            if (blk == OFF_VEC[ADDR_W-1:4]) begin
                case (a[3:2])
                    2'd0:    d.grp = GRP_VEC;
                    2'd1:    d.grp = GRP_BASE;
                    2'd2:    d.grp = GRP_PROT;
                    default: d.grp = GRP_NMI;
                endcase
            end else if (32'(a[3:2]) < NUM_BANKS) begin
                if      (blk == OFF_PEND[ADDR_W-1:4])  d.grp = GRP_PEND;
                else if (blk == OFF_FPEND[ADDR_W-1:4]) d.grp = GRP_FPEND;
                else if (blk == OFF_SEL[ADDR_W-1:4])   d.grp = GRP_SEL;
                else if (blk == OFF_EN[ADDR_W-1:4])    d.grp = GRP_EN;
                else if (blk == OFF_MASK[ADDR_W-1:4])  d.grp = GRP_MASK;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    always_comb begin
        sel = decode_addr(addr);
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int DW = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_sel_t              sel,
    input  logic                  wr_en,
    input  logic [DW-1:0]         wr_data,
    input  logic [NB-1:0][BW-1:0] pend_q,
    input  logic [DW-1:0]         vector_q,
    output logic [NB-1:0][BW-1:0] mask_nxt,
    output logic [NB-1:0][BW-1:0] sel_nxt,
    output logic [DW-1:0]         rd_data
);

    logic [NB-1:0][BW-1:0] mask_q, route_q, en_q, fpend_q;
    logic [DW-1:0]         base_q, prot_q, nmi_q;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (32'(sel.bank) == b);

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[b]  <= '0;
                route_q[b] <= '0;
                en_q[b]    <= '0;
                fpend_q[b] <= '0;
            end else if (hit) begin
                case (sel.grp)
                    GRP_MASK:  mask_q[b]  <= wr_data[BW-1:0];
                    GRP_SEL:   route_q[b] <= wr_data[BW-1:0];
                    GRP_EN:    en_q[b]    <= wr_data[BW-1:0];
                    GRP_FPEND: fpend_q[b] <= fpend_q[b] & ~wr_data[BW-1:0];
                    default:   ;
                endcase
            end
        end

        // values visible to the resolver on the same edge as the write
        always_comb begin
            mask_nxt[b] = (hit && sel.grp == GRP_MASK) ? wr_data[BW-1:0] : mask_q[b];
            sel_nxt[b]  = (hit && sel.grp == GRP_SEL)  ? wr_data[BW-1:0] : route_q[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            prot_q <= '0;
            nmi_q  <= '0;
        end else if (wr_en) begin
            case (sel.grp)
                GRP_BASE: base_q <= {wr_data[DW-1:2], 2'b00};
                GRP_PROT: prot_q <= wr_data;
                GRP_NMI:  nmi_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (sel.grp)
            GRP_VEC:   rd_data = vector_q;
            GRP_BASE:  rd_data = base_q;
            GRP_PROT:  rd_data = prot_q;
            GRP_NMI:   rd_data = nmi_q;
            GRP_PEND:  rd_data = DW'(pend_q[sel.bank]);
            GRP_FPEND: rd_data = DW'(fpend_q[sel.bank]);
            GRP_SEL:   rd_data = DW'(route_q[sel.bank]);
            GRP_EN:    rd_data = DW'(en_q[sel.bank]);
            GRP_MASK:  rd_data = DW'(mask_q[sel.bank]);
            default:   rd_data = '0;
        endcase
    end

    // R7
    base_read_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (sel.grp == GRP_BASE) |-> (rd_data[1:0] == 2'b00));

    // R10
    undecoded_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel.grp == GRP_NONE) |-> (rd_data == '0));

    // R6
    fpend_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((fpend_q & ~$past(fpend_q)) == '0));

endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
    import irqc_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int DW = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NB*BW-1:0]      src,
    input  logic [NB-1:0][BW-1:0] mask_nxt,
    input  logic [NB-1:0][BW-1:0] sel_nxt,
    output logic [NB-1:0][BW-1:0] pend_q,
    output logic [DW-1:0]         vector_q,
    output logic                  irq_q,
    output logic                  fiq_q
);

    localparam int NS = NB * BW;

    logic [NS-1:0] mask_flat, sel_flat, active;
    logic [DW-1:0] vector_d;

    assign mask_flat = mask_nxt;
    assign sel_flat  = sel_nxt;
    assign active    = src & ~mask_flat;

    // lowest active index wins: scan downward so the last hit is the smallest
    always_comb begin
        vector_d = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (active[i]) vector_d = DW'(i * 4);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            vector_q <= '0;
            irq_q    <= 1'b0;
            fiq_q    <= 1'b0;
        end else begin
            pend_q   <= src;
            vector_q <= vector_d;
            irq_q    <= |active;
            fiq_q    <= |(active & sel_flat);
        end
    end

    // R1
    pend_tracks_input_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pend_q == $past(src)));

    // R3
    fiq_implies_irq_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_q |-> irq_q);

    // R4
    vector_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (vector_q != '0) |-> irq_q);

    // R4
    vector_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (vector_q[1:0] == 2'b00) && (vector_q < DW'(NS * 4)));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB*BW-1:0] irq_src,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr_en,
    input  logic [DW-1:0]    reg_wr_data,
    output logic [DW-1:0]    reg_rd_data,
    output logic             cpu_irq,
    output logic             cpu_fiq
);

    reg_sel_t              sel;
    logic [NB-1:0][BW-1:0] mask_nxt, sel_nxt, pend_q;
    logic [DW-1:0]         vector_q;

    irqc_decode u_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    irqc_regs #(.NB(NB), .BW(BW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .pend_q   (pend_q),
        .vector_q (vector_q),
        .mask_nxt (mask_nxt),
        .sel_nxt  (sel_nxt),
        .rd_data  (reg_rd_data)
    );

    irqc_resolve #(.NB(NB), .BW(BW), .DW(DW)) u_resolve (
        .clk      (clk),
        .rst      (rst),
        .src      (irq_src),
        .mask_nxt (mask_nxt),
        .sel_nxt  (sel_nxt),
        .pend_q   (pend_q),
        .vector_q (vector_q),
        .irq_q    (cpu_irq),
        .fiq_q    (cpu_fiq)
    );

    // R5
    pend_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_wr_en && sel.grp == GRP_PEND) && !$past(rst)
        |-> (pend_q == $past(irq_src)));

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int NS = 96;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_src = '0;
    logic [9:0]    reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [31:0]   reg_wr_data = '0;
    logic [31:0]   reg_rd_data;
    logic          cpu_irq, cpu_fiq;

    always #10 clk = ~clk;   // 50 MHz

    irqc_top i_irqc_top (
        .clk         (clk),
        .rst         (rst),
        .irq_src     (irq_src),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .cpu_irq     (cpu_irq),
        .cpu_fiq     (cpu_fiq)
    );

    typedef struct {
        string      req;
        bit         chk_rd;
        logic [31:0] exp_rd;
        bit         e_irq;
        bit         e_fiq;
    } item_t;

    item_t expq[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;

    // model state, from the requirements
    logic [NS-1:0] m_src  = '0;
    logic [NS-1:0] m_mask = '0;
    logic [NS-1:0] m_sel  = '0;

    function automatic bit m_irq();
        return |(m_src & ~m_mask);
    endfunction
    function automatic bit m_fiq();
        return |(m_src & ~m_mask & m_sel);
    endfunction
    function automatic logic [31:0] m_vec();
        for (int i = 0; i < NS; i++)
            if (m_src[i] && !m_mask[i]) return 32'(i * 4);
        return 32'h0;
    endfunction

    function automatic void push(string req, bit chk_rd, logic [31:0] exp_rd);
        item_t it;
        it.req = req; it.chk_rd = chk_rd; it.exp_rd = exp_rd;
        it.e_irq = m_irq(); it.e_fiq = m_fiq();
        expq.push_back(it);
    endfunction

    // monitor: compare after the edge that follows each stimulus
    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            item_t it;
            it = expq.pop_front();
            n_chk++;
            if (cpu_irq !== it.e_irq) begin
                n_err++;
                $display("FAIL %s irq: got %0b expected %0b", it.req, cpu_irq, it.e_irq);
            end
            n_chk++;
            if (cpu_fiq !== it.e_fiq) begin
                n_err++;
                $display("FAIL %s fiq: got %0b expected %0b", it.req, cpu_fiq, it.e_fiq);
            end
            if (it.chk_rd) begin
                n_chk++;
                if (reg_rd_data !== it.exp_rd) begin
                    n_err++;
                    $display("FAIL %s read @%h: got %h expected %h",
                             it.req, reg_addr, reg_rd_data, it.exp_rd);
                end
            end
        end
    end

    task automatic set_src(logic [NS-1:0] v, string req);
        @(negedge clk);
        irq_src = v; reg_wr_en = 1'b0; m_src = v;
        push(req, 1'b0, '0);
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d, string req);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        if (a >= 10'h050 && a <= 10'h058) m_mask[(a - 10'h050) * 8 +: 32] = d;
        if (a >= 10'h030 && a <= 10'h038) m_sel[(a - 10'h030) * 8 +: 32]  = d;
        push(req, 1'b0, '0);
    endtask

    task automatic rd(logic [9:0] a, logic [31:0] e, string req);
        @(negedge clk);
        reg_addr = a; reg_wr_en = 1'b0;
        push(req, 1'b1, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        rd(10'h000, 0, "R9"); rd(10'h004, 0, "R9"); rd(10'h010, 0, "R9");
        rd(10'h030, 0, "R9"); rd(10'h054, 0, "R9"); rd(10'h048, 0, "R9");

        // R1 R2 R4: one source in bank 0
        set_src(NS'(1) << 5, "R2");
        rd(10'h010, 32'h20, "R1");
        rd(10'h000, 32'h14, "R4");

        // R4: a higher source does not displace the lower one
        set_src((NS'(1) << 5) | (NS'(1) << 40), "R4");
        rd(10'h014, 32'h100, "R1");
        rd(10'h000, 32'h14, "R4");

        // R2 R4: masking the lowest moves the vector
        wr(10'h050, 32'h20, "R2");
        rd(10'h000, 32'hA0, "R4");
        rd(10'h050, 32'h20, "R8");

        // R3: routing source 40 to the fast line
        wr(10'h034, 32'h100, "R3");
        rd(10'h034, 32'h100, "R8");
        // R3: masking it drops both lines
        wr(10'h054, 32'h100, "R3");
        rd(10'h000, 32'h0, "R4");
        wr(10'h054, 32'h0, "R3");

        // R8: enable has no effect on outputs
        wr(10'h040, 32'hFFFF_FFFF, "R8");
        wr(10'h044, 32'h0, "R8");
        rd(10'h040, 32'hFFFF_FFFF, "R8");
        rd(10'h000, 32'hA0, "R8");
        wr(10'h008, 32'hDEAD_BEEF, "R8");
        wr(10'h00C, 32'h0000_0007, "R8");
        rd(10'h008, 32'hDEAD_BEEF, "R8");
        rd(10'h00C, 32'h0000_0007, "R8");

        // R5: write to pending ignored
        wr(10'h010, 32'hFFFF_FFFF, "R5");
        rd(10'h010, 32'h20, "R5");
        wr(10'h014, 32'h0, "R5");
        rd(10'h014, 32'h100, "R5");

        // R6: write-one-to-clear, stays zero
        wr(10'h020, 32'hFFFF_FFFF, "R6");
        rd(10'h020, 32'h0, "R6");
        rd(10'h028, 32'h0, "R6");

        // R7: base alignment
        wr(10'h004, 32'h1234_5677, "R7");
        rd(10'h004, 32'h1234_5674, "R7");

        // R10: undecoded addresses
        wr(10'h01C, 32'hFFFF_FFFF, "R10");
        wr(10'h060, 32'hFFFF_FFFF, "R10");
        wr(10'h051, 32'hFFFF_FFFF, "R10");
        wr(10'h3FC, 32'hFFFF_FFFF, "R10");
        rd(10'h01C, 0, "R10"); rd(10'h060, 0, "R10");
        rd(10'h3FC, 0, "R10"); rd(10'h051, 0, "R10");
        rd(10'h050, 32'h20, "R10");
        rd(10'h008, 32'hDEAD_BEEF, "R10");

        // R4: highest source alone
        wr(10'h050, 32'h0, "R4");
        set_src(NS'(1) << 95, "R4");
        rd(10'h000, 32'h17C, "R4");
        rd(10'h018, 32'h8000_0000, "R1");

        // R2 R4: nothing active
        set_src('0, "R2");
        rd(10'h000, 32'h0, "R4");

        // R9: reset mid-run
        set_src(NS'(1) << 40, "R3");
        @(negedge clk);
        rst = 1'b1; m_src = '0; m_mask = '0; m_sel = '0;
        irq_src = '0;
        push("R9", 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        rd(10'h034, 0, "R9"); rd(10'h008, 0, "R9");
        rd(10'h004, 0, "R9"); rd(10'h000, 0, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule